// File: doc/BRIEF.md
# One-Hot Code Self-Checking Checker

This block watches N rails that carry a delay-insensitive 1-out-of-N code word. A valid word has exactly one rail high, so the code has C(N,1) = N valid words. The all-zero word is the spacer that separates one data word from the next.

The block produces two flags. The completion flag is the OR of all rails and says that a word has arrived. The error flag says that two or more rails are high at once. It is built as one two-input AND for each of the C(N,2) rail pairs, and the OR of all those ANDs. It does not count the high rails and compare the count.

The code has Hamming distance 2. A single flipped rail therefore turns a valid word either into the spacer or into a two-hot word, and the block never reports that result as a valid word. The rail count is a parameter, and N=2 gives the dual-rail case. A second parameter selects one of two output stages: flip-flops with a synchronous active-high reset, or a direct combinational path.

Top module: `onehot_chk`

## Requirements
- R1: `done_o` is the OR of all rails, and `err_o` high always comes with `done_o` high.
- R2: `err_o` is 1 exactly when two or more rails are high, for every N-bit pattern.
- R3: When exactly one rail is high, `done_o`=1 and `err_o`=0.
- R4: The all-zero spacer gives `done_o`=0 and `err_o`=0.
- R5: With `REGISTERED`=1, the two flags reflect the rails sampled at the previous rising clock edge. A change on the rails between edges does not reach the outputs until the next edge.
- R6: With `REGISTERED`=1, `rst`=1 at a rising edge clears both flags to 0, whatever the rails carry.
- R7: Flipping any single rail of a valid one-hot word never gives `done_o`=1 with `err_o`=0.
- R8: With N=2 and `REGISTERED`=0, the flags respond in the same cycle: 01 and 10 give `done_o`=1 and `err_o`=0, 11 gives `err_o`=1, and 00 gives both flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered output stage |
| rst | input | 1 | Synchronous active-high reset of the output flags |
| rails_i | input | RAILS | Code word rails, one bit per rail |
| done_o | output | 1 | Completion flag: at least one rail is high |
| err_o | output | 1 | Error flag: two or more rails are high |

## Verification
In the registered build, both flags are due one rising edge after the rails are driven. The bench drives the rails on the falling edge. On every falling edge it compares the outputs with a behavioural model that captures the rails and their popcount at the rising edge. A directed check looks at the outputs just after a new pattern is driven, before the next edge, to confirm that the old result is still there. A dual-rail instance built without registers is checked one time step after each pattern is applied, because its flags are due in the same cycle.

// File: rtl/ohc_pkg.sv
package ohc_pkg;

  // Number of distinct rail pairs, C(n,2).
  function automatic int pair_count(input int n);
    return (n * (n - 1)) / 2;
  endfunction

  // Position of pair (i,j), i<j, in the flat list of pairs.
  function automatic int pair_index(input int i, input int j, input int n);
    return i * n - (i * (i + 1)) / 2 + (j - i - 1);
  endfunction

endpackage

// File: rtl/ohc_pair_and.sv
module ohc_pair_and #(
  parameter int N = 4,
  localparam int PAIRS = ohc_pkg::pair_count(N)
) (
  input  logic [N-1:0]     rails,
  output logic [PAIRS-1:0] pair_hits
);
  // One two-input AND for every unordered pair of rails.
  for (genvar gi = 0; gi < N - 1; gi++) begin : g_row
    for (genvar gj = gi + 1; gj < N; gj++) begin : g_col
      localparam int IDX = ohc_pkg::pair_index(gi, gj, N);
      assign pair_hits[IDX] = rails[gi] & rails[gj];
    end
  end
endmodule

// File: rtl/ohc_or_reduce.sv
module ohc_or_reduce #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             any_o
);
  assign any_o = |vec_i;
endmodule

// File: rtl/ohc_out_stage.sv
module ohc_out_stage #(
  parameter bit REGISTERED = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic done_d,
  input  logic err_d,
  output logic done_q,
  output logic err_q
);
  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end else begin
        done_q <= done_d;
        err_q  <= err_d;
      end
    end
  end else begin : g_comb
    assign done_q = done_d;
    assign err_q  = err_d;
  end
endmodule

// File: rtl/onehot_chk.sv
module onehot_chk #(
  parameter int RAILS      = 4,
  parameter bit REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RAILS-1:0] rails_i,
  output logic             done_o,
  output logic             err_o
);
  localparam int PAIRS = ohc_pkg::pair_count(RAILS);

  logic [PAIRS-1:0] pair_hits;
  logic             done_d;
  logic             err_d;

  // Completion: any rail high.
  ohc_or_reduce #(.WIDTH(RAILS)) u_done_or (
    .vec_i (rails_i),
    .any_o (done_d)
  );

  // Error: any pair of rails high together.
  ohc_pair_and #(.N(RAILS)) u_pairs (
    .rails     (rails_i),
    .pair_hits (pair_hits)
  );

  ohc_or_reduce #(.WIDTH(PAIRS)) u_err_or (
    .vec_i (pair_hits),
    .any_o (err_d)
  );

  ohc_out_stage #(.REGISTERED(REGISTERED)) u_out (
    .clk    (clk),
    .rst    (rst),
    .done_d (done_d),
    .err_d  (err_d),
    .done_q (done_o),
    .err_q  (err_o)
  );
endmodule

// File: rtl/onehot_chk_sva.sv
module onehot_chk_sva #(
  parameter int RAILS      = 4,
  parameter bit REGISTERED = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [RAILS-1:0] rails_i,
  input logic             done_o,
  input logic             err_o
);
  if (REGISTERED) begin : g_reg
    // R1: an error always comes with completion
    a_r1_err_implies_done: assert property (@(posedge clk) disable iff (rst)
      err_o |-> done_o);
    // R2: two or more rails give an error on the next edge
    a_r2_multi_hot: assert property (@(posedge clk) disable iff (rst)
      ($countones(rails_i) >= 2) |=> err_o);
    // R3: exactly one rail gives a clean completion
    a_r3_valid_word: assert property (@(posedge clk) disable iff (rst)
      ($countones(rails_i) == 1) |=> (done_o && !err_o));
    // R4: the spacer clears both flags
    a_r4_spacer: assert property (@(posedge clk) disable iff (rst)
      (rails_i == '0) |=> (!done_o && !err_o));
    // R6: reset clears the outputs
    a_r6_reset_clears: assert property (@(posedge clk)
      rst |=> (!done_o && !err_o));
  end else begin : g_comb
    // R1
    a_r1_err_implies_done: assert property (@(posedge clk) disable iff (rst)
      err_o |-> done_o);
    // R2, R8
    a_r2_multi_hot: assert property (@(posedge clk) disable iff (rst)
      ($countones(rails_i) >= 2) |-> err_o);
    // R3, R8
    a_r3_valid_word: assert property (@(posedge clk) disable iff (rst)
      ($countones(rails_i) == 1) |-> (done_o && !err_o));
    // R4
    a_r4_spacer: assert property (@(posedge clk) disable iff (rst)
      (rails_i == '0) |-> (!done_o && !err_o));
  end
endmodule

bind onehot_chk onehot_chk_sva #(.RAILS(RAILS), .REGISTERED(REGISTERED)) u_sva (
  .clk     (clk),
  .rst     (rst),
  .rails_i (rails_i),
  .done_o  (done_o),
  .err_o   (err_o)
);

// File: tb/onehot_chk_tb.sv
module onehot_chk_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] rails4 = 4'b1111;
  logic [1:0] rails2 = 2'b00;
  logic       done4, err4, done2, err2;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 1'b0;
  string      stim_tag = "R6";

  // Behavioural model state, captured on the rising edge.
  int    m_cnt = 0;
  bit    m_done = 1'b0;
  bit    m_err = 1'b0;
  bit    m_valid = 1'b0;
  string m_tag = "R6";

  always #2 clk = ~clk;

  onehot_chk #(.RAILS(4), .REGISTERED(1'b1)) u_dut (
    .clk(clk), .rst(rst), .rails_i(rails4), .done_o(done4), .err_o(err4));

  onehot_chk #(.RAILS(2), .REGISTERED(1'b0)) u_dut_dr (
    .clk(clk), .rst(rst), .rails_i(rails2), .done_o(done2), .err_o(err2));

  function automatic int popc(input logic [3:0] v);
    int c = 0;
    for (int k = 0; k < 4; k++) c += int'(v[k]);
    return c;
  endfunction

  always @(posedge clk) begin
    m_valid <= 1'b1;
    if (rst) begin
      m_done <= 1'b0;
      m_err  <= 1'b0;
      m_cnt  <= 0;
      m_tag  <= "R6";
    end else begin
      m_cnt  <= popc(rails4);
      m_done <= popc(rails4) >= 1;
      m_err  <= popc(rails4) >= 2;
      m_tag  <= stim_tag;
    end
  end

  task automatic check(input string tag, input logic act_d, input logic act_e,
                       input bit exp_d, input bit exp_e);
    checks++;
    if (act_d !== exp_d || act_e !== exp_e) begin
      errors++;
      $display("FAIL %s: done/err actual=%b%b expected=%b%b", tag, act_d, act_e, exp_d, exp_e);
    end
  endtask

  // Check the registered outputs against the model, then drive the next pattern.
  task automatic cycle(input logic [3:0] p, input string tag);
    string t;
    @(negedge clk);
    if (m_valid) begin
      t = m_tag;
      if (t == "") t = (m_cnt == 0) ? "R4" : (m_cnt == 1) ? "R3" : "R2";
      check(t, done4, err4, m_done, m_err);
      if (t != "R6" && (done4 !== m_done)) $display("FAIL R1: completion mismatch");
      if (t != "R6" && (err4 === 1'b1 && done4 !== 1'b1)) begin
        checks++; errors++;
        $display("FAIL R1: done/err actual=%b%b expected=11", done4, err4);
      end
    end
    rails4 = p;
    stim_tag = tag;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R6: reset holds the flags low with all rails high.
    repeat (3) cycle(4'b1111, "R6");
    @(negedge clk);
    check("R6", done4, err4, 1'b0, 1'b0);
    rst = 1'b0;
    rails4 = 4'b0000;
    stim_tag = "";

    // R1..R4: every 4-bit pattern.
    for (int v = 0; v < 16; v++) cycle(4'(v), "");
    cycle(4'b0000, "");
    cycle(4'b0000, "");

    // R5: a new pattern is not visible before the next edge.
    @(negedge clk);
    rails4 = 4'b0100;
    #1 check("R5", done4, err4, 1'b0, 1'b0);
    @(negedge clk);
    check("R5", done4, err4, 1'b1, 1'b0);
    rails4 = 4'b0110;
    #1 check("R5", done4, err4, 1'b1, 1'b0);
    @(negedge clk);
    check("R5", done4, err4, 1'b1, 1'b1);

    // R7: single flips of every valid word are never seen as valid.
    for (int w = 0; w < 4; w++) begin
      for (int f = 0; f < 4; f++) begin
        logic [3:0] word;
        word = 4'(1 << w) ^ 4'(1 << f);
        @(negedge clk);
        rails4 = word;
        @(negedge clk);
        checks++;
        if (done4 === 1'b1 && err4 === 1'b0) begin
          errors++;
          $display("FAIL R7: word=%b done/err actual=%b%b expected=not 10", word, done4, err4);
        end
      end
    end
    cycle(4'b0000, "");

    // R6: reset in mid-run with an error word on the rails.
    @(negedge clk);
    rails4 = 4'b1011;
    rst = 1'b1;
    @(negedge clk);
    check("R6", done4, err4, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R2", done4, err4, 1'b1, 1'b1);

    // R8: the dual-rail instance without registers.
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      rails2 = 2'(v);
      #1 check("R8", done2, err2, v != 0, v == 3);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule